// File: doc/BRIEF.md
# Soft Mute Ramp Controller

This block fades a stereo stream of 24-bit two's-complement samples down to silence, and back up to full level, whenever a mute request changes. The fade is linear. The gain moves by one step on each word-clock tick, and the step size is set by the speed mode, so that a complete fade lasts 1152 ticks in single speed, 2304 in double speed and 4608 in quad speed. A request in the opposite direction during a fade reverses it from the current gain, so the level never jumps.

An active-low mute-control output tells an external mute circuit when the stream is silent. It goes low only once a fade toward mute has reached zero gain. It goes high on the cycle after an unmute request, before the level has started to rise. It is also held low during reset, power-down and while the clock-ratio error flag is raised. Power-down also drops the gain straight to zero.

Top module: `soft_mute_ramp`

## Requirements
- R1: While reset is low and on the first cycle after reset, both sample outputs are zero, mute_ctl_n is 0 and the gain is zero.
- R2: Under a mute request, starting from full gain, the gain reaches zero after exactly 1152 ticks for speed code 00, 2304 for code 01 and 4608 for codes 10 and 11. The gain changes only on cycles where wclk_tick is 1.
- R3: After a release, starting from zero gain, the gain reaches full scale (4608) after the same per-mode tick count, and the outputs then equal the inputs.
- R4: With power-down and ratio error both clear, mute_ctl_n goes low only on the cycle after the gain has reached zero under a mute request. It is never low while the gain is nonzero.
- R5: If mute_req_n is 1 and power-down and ratio error are clear, mute_ctl_n is 1 on the next cycle, even while the gain is still zero.
- R6: If pwr_down or ratio_err is 1, mute_ctl_n is 0 on the next cycle. If pwr_down is 1, the gain is also forced to zero on the next cycle.
- R7: A request in the opposite direction during a fade continues from the current gain. The gain never moves by more than one step (at most 4) per cycle, except when power-down forces it to zero.
- R8: Each output equals its input sample multiplied by gain/4608, truncated toward zero and clamped to the 24-bit signed range. It is registered one cycle after the input. Zero gain gives exactly zero.
- R9: mute_req_n = 0 requests mute and mute_req_n = 1 requests normal level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Power-down: forces zero gain and holds mute_ctl_n low |
| ratio_err | input | 1 | Master-clock to word-clock ratio invalid; holds mute_ctl_n low |
| mute_req_n | input | 1 | 0 requests mute, 1 requests normal level |
| speed | input | 2 | 00 single, 01 double, 1x quad speed |
| wclk_tick | input | 1 | One-cycle pulse per word-clock period |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| mute_ctl_n | output | 1 | Low when the output is silent or the block is held inactive |

## Verification
The assertions check on every cycle that the gain stays in range and moves only on ticks, that it never moves by more than one step, that zero gain gives zero samples, and the relation between mute_ctl_n, the gain and the forcing inputs. The length of each fade per speed mode, the reversal from a mid-fade gain, and the exact truncated products over random samples can only be shown by the bench's scenarios. These are compared cycle by cycle against its behavioural model.

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int W          = 24,
  parameter int BASE_TICKS = 1152
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_down,
  input  logic                ratio_err,
  input  logic                mute_req_n,
  input  logic [1:0]          speed,
  input  logic                wclk_tick,
  input  logic signed [W-1:0] in_left,
  input  logic signed [W-1:0] in_right,
  output logic signed [W-1:0] out_left,
  output logic signed [W-1:0] out_right,
  output logic                mute_ctl_n
);
  localparam int FULL = BASE_TICKS * 4;
  localparam int LW   = $clog2(FULL + 1);
  localparam int PW   = W + LW + 1;
  localparam logic [LW-1:0]        FULL_L = LW'(FULL);
  localparam logic signed [PW-1:0] DIV    = PW'(FULL);
  localparam logic signed [PW-1:0] QMAX   = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] QMIN   = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic [LW-1:0] lvl, lvl_nxt, step;

  assign step = (speed == 2'b00) ? LW'(4) : (speed == 2'b01) ? LW'(2) : LW'(1);

  always_comb begin
    lvl_nxt = lvl;
    if (pwr_down)
      lvl_nxt = '0;
    else if (wclk_tick) begin
      if (!mute_req_n)
        lvl_nxt = (lvl > step) ? lvl - step : '0;
      else
        lvl_nxt = ((FULL_L - lvl) > step) ? lvl + step : FULL_L;
    end
  end

  function automatic logic signed [W-1:0] scale(input logic signed [W-1:0] s,
                                                input logic [LW-1:0] g);
    logic signed [PW-1:0] p, q;
    p = PW'(s) * $signed(PW'(g));
    q = p / DIV;
    if (q > QMAX)      scale = QMAX[W-1:0];
    else if (q < QMIN) scale = QMIN[W-1:0];
    else               scale = q[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl        <= '0;
      out_left   <= '0;
      out_right  <= '0;
      mute_ctl_n <= 1'b0;
    end else begin
      lvl        <= lvl_nxt;
      out_left   <= scale(in_left, lvl);
      out_right  <= scale(in_right, lvl);
      mute_ctl_n <= !(pwr_down || ratio_err || (!mute_req_n && lvl_nxt == '0));
    end
  end
endmodule

// File: rtl/soft_mute_ramp_chk.sv
module soft_mute_ramp_chk #(
  parameter int W  = 24,
  parameter int LW = 13,
  parameter int FULL = 4608
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_down,
  input logic                ratio_err,
  input logic                mute_req_n,
  input logic                wclk_tick,
  input logic [LW-1:0]       lvl,
  input logic signed [W-1:0] out_left,
  input logic signed [W-1:0] out_right,
  input logic                mute_ctl_n
);
  a_r2_gain_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(FULL));

  a_r2_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!wclk_tick && !pwr_down) |=> $stable(lvl));

  a_r7_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down |=> (((lvl >= $past(lvl)) ? (lvl - $past(lvl)) : ($past(lvl) - lvl)) <= LW'(4)));

  a_r4_low_only_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && !ratio_err) |=> (mute_ctl_n || lvl == '0));

  a_r5_release_now: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_req_n && !pwr_down && !ratio_err) |=> mute_ctl_n);

  a_r6_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down || ratio_err) |=> !mute_ctl_n);

  a_r6_pd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (lvl == '0));

  a_r8_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |=> (out_left == '0 && out_right == '0));
endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(.W(W), .LW(LW), .FULL(FULL)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .ratio_err(ratio_err),
  .mute_req_n(mute_req_n), .wclk_tick(wclk_tick), .lvl(lvl),
  .out_left(out_left), .out_right(out_right), .mute_ctl_n(mute_ctl_n));

// File: tb/soft_mute_ramp_bench.sv
module soft_mute_ramp_bench;
  localparam int FULL = 4608;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_down = 1'b0, ratio_err = 1'b0, mute_req_n = 1'b0;
  logic [1:0] speed = 2'b00;
  logic wclk_tick = 1'b0;
  logic signed [23:0] in_left = '0, in_right = '0;
  logic signed [23:0] out_left, out_right;
  logic mute_ctl_n;

  int tests = 0, fails = 0, cyc = 0, ticks_seen = 0;
  bit tick_en = 1'b0, rand_en = 1'b1;
  int tdiv = 0;

  longint mlvl = 0, el = 0, er = 0;
  bit em = 1'b0;

  always #5 clk = ~clk;

  soft_mute_ramp u_soft_mute_ramp (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .ratio_err(ratio_err),
    .mute_req_n(mute_req_n), .speed(speed), .wclk_tick(wclk_tick),
    .in_left(in_left), .in_right(in_right), .out_left(out_left),
    .out_right(out_right), .mute_ctl_n(mute_ctl_n));

  function automatic longint mscale(longint s, longint g);
    longint q;
    q = (s * g) / FULL;
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return q;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus generators for tick and random data
  always @(negedge clk) begin
    if (tick_en) begin
      tdiv = (tdiv + 1) % 4;
      wclk_tick <= (tdiv == 0);
    end else
      wclk_tick <= 1'b0;
    if (rand_en) begin
      in_left  <= 24'($urandom);
      in_right <= 24'($urandom);
    end
  end

  // behavioural reference model
  always @(posedge clk) begin
    longint st;
    cyc++;
    if (cyc > 190000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      summary();
    end
    if (!rst_n) begin
      mlvl = 0; el = 0; er = 0; em = 1'b0;
    end else begin
      el = mscale(longint'(in_left), mlvl);
      er = mscale(longint'(in_right), mlvl);
      st = (speed == 2'b00) ? 4 : (speed == 2'b01) ? 2 : 1;
      if (wclk_tick) ticks_seen++;
      if (pwr_down) mlvl = 0;
      else if (wclk_tick) begin
        if (!mute_req_n) mlvl = (mlvl > st) ? mlvl - st : 0;
        else             mlvl = (FULL - mlvl > st) ? mlvl + st : FULL;
      end
      em = !(pwr_down || ratio_err || (!mute_req_n && mlvl == 0));
    end
  end

  // every-cycle comparison against model (R8 samples, R4/R5 mute control)
  always @(negedge clk) begin
    check(longint'(out_left) == el, "R8 out_left", longint'(out_left), el);
    check(longint'(out_right) == er, "R8 out_right", longint'(out_right), er);
    check(mute_ctl_n == em, "R4/R5 mute_ctl_n", longint'(mute_ctl_n), longint'(em));
  end

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure_down(int exp, string req);
    int start, guard;
    @(negedge clk);
    mute_req_n = 1'b0;
    start = ticks_seen;
    guard = 0;
    @(negedge clk);
    check(mute_ctl_n == 1'b1, "R4 still high at fade start", mute_ctl_n, 1);
    while (mute_ctl_n && guard < 30000) begin @(negedge clk); guard++; end
    check(ticks_seen - start == exp, req, ticks_seen - start, exp);
  endtask

  task automatic measure_up(int exp, string req);
    int start, guard;
    @(negedge clk);
    rand_en = 1'b0;
    in_left = 24'sh7FFFFF; in_right = -24'sh800000;
    mute_req_n = 1'b1;
    start = ticks_seen;
    guard = 0;
    @(negedge clk);
    check(mute_ctl_n == 1'b1, "R5 released at once", mute_ctl_n, 1);
    while (out_left != in_left && guard < 30000) begin @(negedge clk); guard++; end
    check(ticks_seen - start == exp, req, ticks_seen - start, exp);
    check(out_right == in_right, "R3 full gain right", out_right, in_right);
    rand_en = 1'b1;
  endtask

  initial begin
    int start;
    wait_cycles(4);
    check(out_left == 0 && out_right == 0, "R1 outputs zero in reset", out_left, 0);
    check(mute_ctl_n == 1'b0, "R1 mute_ctl_n low in reset", mute_ctl_n, 0);
    rst_n = 1'b1;
    tick_en = 1'b1;
    wait_cycles(1);
    check(out_left == 0, "R1 zero after reset", out_left, 0);
    wait_cycles(40);
    check(mute_ctl_n == 1'b0, "R9 mute_req_n=0 keeps muted", mute_ctl_n, 0);
    check(out_left == 0, "R9 muted output zero", out_left, 0);

    speed = 2'b00;
    measure_up(1152, "R3 single-speed rise ticks");
    wait_cycles(20);
    measure_down(1152, "R2 single-speed fall ticks");
    speed = 2'b01;
    measure_up(2304, "R3 double-speed rise ticks");
    measure_down(2304, "R2 double-speed fall ticks");
    speed = 2'b10;
    measure_up(4608, "R3 quad-speed rise ticks");
    speed = 2'b11;
    measure_down(4608, "R2 quad-speed (code 11) fall ticks");

    // R7: reverse after 100 ticks of rise
    speed = 2'b00;
    @(negedge clk);
    mute_req_n = 1'b1;
    start = ticks_seen;
    while (ticks_seen - start < 100) @(negedge clk);
    measure_down(100, "R7 reversal returns in same tick count");

    // R6: power-down and ratio error
    measure_up(1152, "R3 rise before forcing");
    @(negedge clk);
    pwr_down = 1'b1;
    wait_cycles(1);
    check(mute_ctl_n == 1'b0, "R6 pwr_down forces low", mute_ctl_n, 0);
    wait_cycles(1);
    check(out_left == 0, "R6 pwr_down zero output", out_left, 0);
    pwr_down = 1'b0;
    measure_up(1152, "R6 rise again after power-down");
    @(negedge clk);
    ratio_err = 1'b1;
    wait_cycles(1);
    check(mute_ctl_n == 1'b0, "R6 ratio_err forces low", mute_ctl_n, 0);
    wait_cycles(2);
    check(out_left != 0 || in_left == 0, "R6 ratio_err keeps gain", out_left, 1);
    ratio_err = 1'b0;
    wait_cycles(1);
    check(mute_ctl_n == 1'b1, "R6 released after ratio_err", mute_ctl_n, 1);
    wait_cycles(10);
    summary();
  end
endmodule